// File: doc/BRIEF.md
# Triggered Four-Channel Conversion Sequencer

This block is the digital controller that runs an external analog-to-digital converter in hardware-trigger scan mode. Software sets it up through a small write-only register port. A control word holds an enable bit and a run bit, and a group word picks which block of consecutive channels a scan covers. Once the block is enabled it sits in standby. A hardware trigger pulse starts a scan. The block then walks the channels of the selected group in ascending order and hands each one to the converter over a start/channel/done handshake. For every finished conversion it stores the result together with its channel and raises a one-cycle end-of-conversion interrupt.

The scan keeps looping over its group until something stops it or restarts it. Three events restart the scan at the first channel of the group and throw away the conversion in flight: a new trigger, any write to the group word, and a write that sets the run bit again. Clearing the run bit drops the block back to standby, and clearing the enable bit stops it. Every abort sends a one-cycle cancel to the converter. A done pulse that arrives in the same cycle as an abort is discarded.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is stopped: enabled_o, running_o, eoc_irq_o, conv_start_o and conv_cancel_o are 0, and result_o and result_ch_o are 0.
- R2: A control write (reg_addr 0) with wdata bit 0 = 1 while disabled sets enabled_o and leaves running_o at 0. No conversion starts until a trigger arrives. While disabled, bit 1 of that same write is ignored.
- R3: While enabled_o is 0, hw_trig pulses are ignored: running_o stays 0 and conv_start_o stays low.
- R4: An hw_trig pulse in standby sets running_o one cycle later and issues conv_start_o in that cycle. conv_ch_o equals the group's first channel.
- R5: The channels of a group are converted in ascending order and wrap from the last back to the first. An accepted conv_done_i updates result_o and result_ch_o and raises eoc_irq_o for exactly one cycle, in the cycle after done. The start of the next channel is issued in that same cycle.
- R6: An hw_trig pulse while running aborts the conversion in flight. conv_cancel_o pulses, together with a new start on the group's first channel, and no result or interrupt is produced for the aborted conversion.
- R7: A write to the group word (reg_addr 1) while running aborts and restarts the scan on the first channel of the newly written group. This holds even when the written value is unchanged, and conv_cancel_o pulses.
- R8: A control write with bits 1:0 = 2'b11 while enabled restarts the scan at the group's first channel, with a cancel if a conversion was in flight. The same write in standby starts a scan with no cancel.
- R9: A control write with bits 1:0 = 2'b01 while running pulses conv_cancel_o and clears running_o. result_o and eoc_irq_o then stay unchanged, and no new start follows.
- R10: Group word bit 0 = 0 selects channels 0 to 3 and bit 0 = 1 selects channels 4 to 7. Every conv_ch_o issued lies in the selected group.
- R11: A control write with bit 0 = 0 while running pulses conv_cancel_o, clears enabled_o and running_o, and issues no further starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = group word |
| reg_wdata | input | 8 | Write data |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_ch_o | output | 3 | Channel for the conversion being started |
| conv_cancel_o | output | 1 | One-cycle abort of the conversion in flight |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 10 | Converter result, valid with done |
| result_o | output | 10 | Last stored result |
| result_ch_o | output | 3 | Channel of the last stored result |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |
| enabled_o | output | 1 | Enable bit |
| running_o | output | 1 | Run/status bit |

## Verification
A wrong sequencer state shows at the ports within one cycle of the event that exposes it. A stale channel index or group base puts the wrong channel on the very next start pulse. An abort that the block fails to take shows up either as a missing cancel in the cycle after the trigger or write, or as an interrupt that still arrives for the discarded conversion. A bad result path shows at the first interrupt, because the stored value or channel then differs from what the converter model returned one cycle earlier. The bench therefore compares every start channel, every interrupt and the enable and run bits against its own model in every cycle, so any divergence is caught at the first affected port event.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_STOP    = 2'd0,
      SEQ_STANDBY = 2'd1,
      SEQ_LAUNCH  = 2'd2,
      SEQ_WAIT    = 2'd3
   } seq_state_e;

   localparam logic ADDR_CTRL  = 1'b0;
   localparam logic ADDR_GROUP = 1'b1;
   localparam int   CTRL_EN_BIT = 0;
   localparam int   CTRL_GO_BIT = 1;

   typedef struct packed {
      logic disable_ev;
      logic enable_ev;
      logic halt_ev;
      logic go_ev;
      logic group_ev;
      logic trig_ev;
   } seq_cmd_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int GROUPS  = 2,
   parameter int GRP_W   = 1,
   parameter int WDATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [WDATA_W-1:0] reg_wdata,
   input  logic               hw_trig,
   output logic               en_q,
   output logic [GRP_W-1:0]   grp_q,
   output seq_cmd_t           cmd
);

   logic ctrl_wr;
   logic grp_wr;
   logic unused_wdata;

   assign ctrl_wr      = reg_wr && (reg_addr == ADDR_CTRL);
   assign grp_wr       = reg_wr && (reg_addr == ADDR_GROUP);
   assign unused_wdata = ^reg_wdata;

   always_comb begin
      cmd            = '0;
      cmd.disable_ev = ctrl_wr && !reg_wdata[CTRL_EN_BIT] && en_q;
      cmd.enable_ev  = ctrl_wr &&  reg_wdata[CTRL_EN_BIT] && !en_q;
      cmd.halt_ev    = ctrl_wr &&  reg_wdata[CTRL_EN_BIT] && en_q && !reg_wdata[CTRL_GO_BIT];
      cmd.go_ev      = ctrl_wr &&  reg_wdata[CTRL_EN_BIT] && en_q &&  reg_wdata[CTRL_GO_BIT];
      cmd.group_ev   = grp_wr;
      cmd.trig_ev    = hw_trig && en_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q <= reg_wdata[CTRL_EN_BIT];
      end
   end

   generate
      if (GROUPS > 1) begin : g_grp_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               grp_q <= '0;
            end else if (grp_wr) begin
               grp_q <= reg_wdata[GRP_W-1:0];
            end
         end
      end else begin : g_grp_fixed
         assign grp_q = '0;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int SCAN_LEN = 4,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_cmd_t         cmd,
   input  logic             conv_done_i,
   output seq_state_e       state_q,
   output logic [IDX_W-1:0] idx_q,
   output logic             cancel_q,
   output logic             accept
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCAN_LEN - 1);

   seq_state_e       state_d;
   logic [IDX_W-1:0] idx_d;
   logic             cancel_d;
   logic             busy;
   logic             restart;

   assign busy    = (state_q == SEQ_LAUNCH) || (state_q == SEQ_WAIT);
   assign restart = cmd.trig_ev || cmd.go_ev || (cmd.group_ev && busy);

   always_comb begin
      state_d  = state_q;
      idx_d    = idx_q;
      cancel_d = 1'b0;
      accept   = 1'b0;
      if (cmd.disable_ev) begin
         state_d  = SEQ_STOP;
         cancel_d = busy;
      end else if (cmd.enable_ev) begin
         state_d  = SEQ_STANDBY;
      end else if (cmd.halt_ev) begin
         state_d  = SEQ_STANDBY;
         cancel_d = busy;
      end else if (restart) begin
         state_d  = SEQ_LAUNCH;
         idx_d    = '0;
         cancel_d = busy;
      end else begin
         case (state_q)
            SEQ_LAUNCH: state_d = SEQ_WAIT;
            SEQ_WAIT: begin
               if (conv_done_i) begin
                  accept  = 1'b1;
                  state_d = SEQ_LAUNCH;
                  idx_d   = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
               end
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_STOP;
         idx_q    <= '0;
         cancel_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         idx_q    <= idx_d;
         cancel_q <= cancel_d;
      end
   end

   AST_CANCEL_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_q |-> ($past(state_q) == SEQ_LAUNCH || $past(state_q) == SEQ_WAIT)); // R6

   AST_STOP_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.disable_ev |=> (state_q == SEQ_STOP)); // R11

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
   parameter int DATA_W = 10,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CH_W-1:0]   cur_ch,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic [DATA_W-1:0] result_q,
   output logic [CH_W-1:0]   result_ch_q,
   output logic              eoc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q    <= '0;
         result_ch_q <= '0;
         eoc_q       <= 1'b0;
      end else begin
         eoc_q <= accept;
         if (accept) begin
            result_q    <= conv_data_i;
            result_ch_q <= cur_ch;
         end
      end
   end

   AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_q |=> !eoc_q); // R5

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_q |-> ($stable(result_q) && $stable(result_ch_q))); // R9

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int SCAN_LEN = 4,
   parameter int GROUPS   = 2,
   parameter int CH_W     = 3,
   parameter int DATA_W   = 10,
   parameter int WDATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [WDATA_W-1:0] reg_wdata,
   input  logic               hw_trig,
   output logic               conv_start_o,
   output logic [CH_W-1:0]    conv_ch_o,
   output logic               conv_cancel_o,
   input  logic               conv_done_i,
   input  logic [DATA_W-1:0]  conv_data_i,
   output logic [DATA_W-1:0]  result_o,
   output logic [CH_W-1:0]    result_ch_o,
   output logic               eoc_irq_o,
   output logic               enabled_o,
   output logic               running_o
);

   localparam int IDX_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1;
   localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

   generate
      if (SCAN_LEN < 2 || (SCAN_LEN & (SCAN_LEN - 1)) != 0) begin : g_bad_len
         $error("SCAN_LEN must be a power of two of at least 2");
      end
      if ((GROUPS & (GROUPS - 1)) != 0) begin : g_bad_groups
         $error("GROUPS must be a power of two");
      end
      if (GROUPS * SCAN_LEN > (1 << CH_W)) begin : g_bad_chw
         $error("CH_W too narrow for GROUPS * SCAN_LEN channels");
      end
      if (WDATA_W < 2 || GRP_W > WDATA_W) begin : g_bad_wdata
         $error("WDATA_W too narrow for the register fields");
      end
   endgenerate

   seq_cmd_t         cmd;
   logic             en_q;
   logic [GRP_W-1:0] grp_q;
   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             cancel_q;
   logic             accept;
   logic [CH_W-1:0]  cur_ch;
   logic [CH_W-1:0]  base_ch;

   adc_seq_regs #(
      .GROUPS (GROUPS),
      .GRP_W  (GRP_W),
      .WDATA_W(WDATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .hw_trig  (hw_trig),
      .en_q     (en_q),
      .grp_q    (grp_q),
      .cmd      (cmd)
   );

   adc_seq_fsm #(
      .SCAN_LEN(SCAN_LEN),
      .IDX_W   (IDX_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .conv_done_i(conv_done_i),
      .state_q    (state_q),
      .idx_q      (idx_q),
      .cancel_q   (cancel_q),
      .accept     (accept)
   );

   assign base_ch = CH_W'(int'(grp_q) * SCAN_LEN);
   assign cur_ch  = base_ch + CH_W'(idx_q);

   adc_seq_result #(
      .DATA_W(DATA_W),
      .CH_W  (CH_W)
   ) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .cur_ch     (cur_ch),
      .conv_data_i(conv_data_i),
      .result_q   (result_o),
      .result_ch_q(result_ch_o),
      .eoc_q      (eoc_irq_o)
   );

   assign conv_start_o  = (state_q == SEQ_LAUNCH);
   assign conv_ch_o     = cur_ch;
   assign conv_cancel_o = cancel_q;
   assign enabled_o     = en_q;
   assign running_o     = (state_q == SEQ_LAUNCH) || (state_q == SEQ_WAIT);

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled_o |-> !conv_start_o); // R3

   AST_RESTART_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_cancel_o && running_o) |-> (conv_start_o && conv_ch_o == base_ch)); // R6

   AST_CH_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> (int'(conv_ch_o) / SCAN_LEN == int'(grp_q))); // R10

   AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_trig && enabled_o && !reg_wr) |=> (running_o && conv_start_o)); // R4

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

   localparam int LAT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       hw_trig = 1'b0;
   logic       conv_start_o;
   logic [2:0] conv_ch_o;
   logic       conv_cancel_o;
   logic       conv_done_i;
   logic [9:0] conv_data_i;
   logic [9:0] result_o;
   logic [2:0] result_ch_o;
   logic       eoc_irq_o;
   logic       enabled_o;
   logic       running_o;

   always #10 clk = ~clk;

   adc_scan_seq u_adc_scan_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .hw_trig      (hw_trig),
      .conv_start_o (conv_start_o),
      .conv_ch_o    (conv_ch_o),
      .conv_cancel_o(conv_cancel_o),
      .conv_done_i  (conv_done_i),
      .conv_data_i  (conv_data_i),
      .result_o     (result_o),
      .result_ch_o  (result_ch_o),
      .eoc_irq_o    (eoc_irq_o),
      .enabled_o    (enabled_o),
      .running_o    (running_o)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int base_of(input int g);
      return g * 4;
   endfunction

   function automatic int next_ch(input int c);
      return (c & ~3) | ((c + 1) & 3);
   endfunction

   function automatic logic [9:0] conv_value(input int ch, input int n);
      return 10'((ch * 97 + n * 29 + 5) & 1023);
   endfunction

   // converter model: fixed latency, cancel drops the conversion
   logic       m_busy = 1'b0;
   int         m_cnt = 0;
   int         m_ch = 0;
   int         m_seq = 0;
   int         m_done_ch = 0;

   initial begin
      conv_done_i = 1'b0;
      conv_data_i = '0;
   end

   always @(posedge clk) begin
      conv_done_i <= 1'b0;
      if (!rst_n) begin
         m_busy <= 1'b0;
      end else if (conv_start_o) begin
         m_busy <= 1'b1;
         m_cnt  <= LAT;
         m_ch   <= int'(conv_ch_o);
      end else if (conv_cancel_o) begin
         m_busy <= 1'b0;
      end else if (m_busy) begin
         m_cnt <= m_cnt - 1;
         if (m_cnt == 1) begin
            m_busy      <= 1'b0;
            conv_done_i <= 1'b1;
            conv_data_i <= conv_value(m_ch, m_seq);
            m_done_ch   <= m_ch;
            m_seq       <= m_seq + 1;
         end
      end
   end

   // expected state, updated by the stimulus tasks after each edge
   bit exp_en = 1'b0;
   bit exp_run = 1'b0;
   int exp_grp = 0;
   int exp_ch = 0;

   int start_cnt = 0;
   int cancel_cnt = 0;
   int eoc_cnt = 0;
   int last_start_ch = 0;
   bit prev_done = 1'b0;
   int prev_data = 0;
   int prev_dch = 0;

   always begin
      @(negedge clk);
      #5;
      if (rst_n) begin
         check(enabled_o == exp_en, "R2 enabled_o", int'(enabled_o), int'(exp_en));
         check(running_o == exp_run, "R9 running_o", int'(running_o), int'(exp_run));
         if (conv_cancel_o) cancel_cnt++;
         if (conv_start_o) begin
            start_cnt++;
            last_start_ch = int'(conv_ch_o);
            check(exp_run, "R3 start while not running", 1, 0);
            check(int'(conv_ch_o) == exp_ch, "R5 start channel", int'(conv_ch_o), exp_ch);
            check(int'(conv_ch_o) / 4 == exp_grp, "R10 channel group", int'(conv_ch_o) / 4, exp_grp);
            exp_ch = next_ch(exp_ch);
         end
         if (eoc_irq_o) begin
            eoc_cnt++;
            check(prev_done, "R5 eoc follows done", 0, 1);
            check(int'(result_o) == prev_data, "R5 result value", int'(result_o), prev_data);
            check(int'(result_ch_o) == prev_dch, "R5 result channel", int'(result_ch_o), prev_dch);
         end
         prev_done = conv_done_i;
         prev_data = int'(conv_data_i);
         prev_dch  = m_done_ch;
      end
   end

   task automatic wr(input bit addr, input int data);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = addr;
      reg_wdata = 8'(data);
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      if (addr == 1'b1) begin
         exp_grp = data & 1;
         if (exp_run) exp_ch = base_of(exp_grp);
      end else if ((data & 1) == 0) begin
         exp_en  = 1'b0;
         exp_run = 1'b0;
      end else if (!exp_en) begin
         exp_en = 1'b1;
      end else if ((data & 2) != 0) begin
         exp_run = 1'b1;
         exp_ch  = base_of(exp_grp);
      end else begin
         exp_run = 1'b0;
      end
   endtask

   task automatic trig();
      @(negedge clk);
      hw_trig = 1'b1;
      @(posedge clk);
      #1;
      hw_trig = 1'b0;
      if (exp_en) begin
         exp_run = 1'b1;
         exp_ch  = base_of(exp_grp);
      end
   endtask

   task automatic wait_start();
      int s0 = start_cnt;
      for (int i = 0; i < 200 && start_cnt == s0; i++) @(posedge clk);
      check(start_cnt != s0, "R5 start expected", start_cnt, s0 + 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_eocs(input int n);
      int target = eoc_cnt + n;
      for (int i = 0; i < 2000 && eoc_cnt < target; i++) @(posedge clk);
      check(eoc_cnt >= target, "R5 eoc count", eoc_cnt, target);
   endtask

   // after an abort command: check cancel and restart channel
   task automatic check_abort(input string req, input int c0, input int e0,
                              input int s0, input int exp_start);
      @(negedge clk);
      #6;
      check(cancel_cnt == c0 + 1, req, cancel_cnt, c0 + 1);
      check(eoc_cnt == e0, req, eoc_cnt, e0);
      if (exp_start >= 0) begin
         check(start_cnt == s0 + 1, req, start_cnt, s0 + 1);
         check(last_start_ch == exp_start, req, last_start_ch, exp_start);
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int c0;
      int e0;
      int s0;
      int r0;
      void'($urandom(32'd2024));
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      #6;
      // R1 reset state
      check(!enabled_o && !running_o, "R1 enable/run", int'(enabled_o), 0);
      check(!eoc_irq_o && !conv_start_o && !conv_cancel_o, "R1 pulses", int'(eoc_irq_o), 0);
      check(result_o == 0 && result_ch_o == 0, "R1 result", int'(result_o), 0);

      // R3 trigger ignored while disabled
      s0 = start_cnt;
      trig();
      repeat (10) @(negedge clk);
      check(start_cnt == s0 && !running_o, "R3 trigger ignored", start_cnt, s0);

      // R2 enable enters standby, run bit of the same write ignored
      wr(1'b0, 3);
      repeat (10) @(negedge clk);
      check(start_cnt == s0, "R2 no start in standby", start_cnt, s0);

      // R4 trigger starts at channel 0
      trig();
      @(negedge clk);
      #6;
      check(running_o && last_start_ch == 0 && start_cnt == s0 + 1, "R4 trigger start",
            last_start_ch, 0);

      // R5 two full passes with wrap
      wait_eocs(8);
      check(result_ch_o == 3, "R5 wrap channel", int'(result_ch_o), 3);

      // R6 retrigger while converting
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt;
      trig();
      check_abort("R6 retrigger", c0, e0, s0, 0);

      // R7 group rewrite, new group and same value
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt;
      wr(1'b1, 1);
      check_abort("R7 group write", c0, e0, s0, 4);
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt;
      wr(1'b1, 1);
      check_abort("R7 same group write", c0, e0, s0, 4);

      // R8 run-bit rewrite during conversion
      wait_eocs(2);
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt;
      wr(1'b0, 3);
      check_abort("R8 run rewrite", c0, e0, s0, 4);

      // R9 clear run bit
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt; r0 = int'(result_o);
      wr(1'b0, 1);
      check_abort("R9 halt", c0, e0, s0, -1);
      repeat (30) @(negedge clk);
      check(int'(result_o) == r0 && eoc_cnt == e0, "R9 result held", int'(result_o), r0);
      check(start_cnt == s0, "R9 no start", start_cnt, s0);

      // R8 software start from standby: no cancel
      c0 = cancel_cnt; s0 = start_cnt;
      wr(1'b0, 3);
      @(negedge clk);
      #6;
      check(cancel_cnt == c0 && last_start_ch == 4 && start_cnt == s0 + 1,
            "R8 start from standby", last_start_ch, 4);

      // R11 disable while converting
      wait_start();
      c0 = cancel_cnt; e0 = eoc_cnt; s0 = start_cnt;
      wr(1'b0, 0);
      check_abort("R11 disable", c0, e0, s0, -1);
      trig();
      repeat (20) @(negedge clk);
      check(start_cnt == s0 && !enabled_o, "R11 stays stopped", start_cnt, s0);

      // constrained random mix
      wr(1'b0, 1);
      e0 = eoc_cnt;
      for (int it = 0; it < 400; it++) begin
         int op;
         repeat ($urandom % 10) @(negedge clk);
         op = int'($urandom % 9);
         case (op)
            0, 1: trig();
            2: wr(1'b1, int'($urandom % 2));
            3: wr(1'b0, 3);
            4: wr(1'b0, 1);
            5: begin wr(1'b0, 0); wr(1'b0, 1); end
            default: repeat (25) @(negedge clk);
         endcase
      end
      check(eoc_cnt > e0, "R5 random run produced results", eoc_cnt - e0, 1);

      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule